// File: doc/BRIEF.md
# Dual Timer/Counter Pair

This block holds two identical up-counting channels. Each channel keeps a low byte and a high byte and advances on either a free-running internal tick (an oscillator divided down ahead of the block) or on rising edges of its own external count pin. An 8-bit mode register picks each channel's operating mode, its count source and whether an external interrupt pin gates it. A small control register holds a run bit and an overflow flag for each channel.

The four modes are:
- a 13-bit count, in which five bits of the low byte prescale by 32 into the high byte;
- a plain 16-bit count;
- an 8-bit count that refills the low byte from the high byte on every wrap;
- a split mode in which channel 0 becomes two 8-bit counters. The second of these uses channel 1's run bit and flag.

An overflow sets the channel's flag and produces a one-cycle pulse. The flag clears when the interrupt controller returns an acknowledge strobe for that channel.

The processor writes configuration and counts through a single byte-wide write port. The count registers, mode register and control bits are all visible as registered outputs.

Top module: `tmrcnt_pair`

## Requirements
- R1: After synchronous reset, every count byte, the mode register, all run bits, all flags and the overflow pulses are 0.
- R2: Write port codes for `wr_sel` are: 0 mode register, 1 control (`wr_data[7:4]` = {flag1, run1, flag0, run0}), 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. A byte write wins over a count of that channel in the same cycle; in split mode each byte of channel 0 is blocked only by a write to itself.
- R3: Mode register bits [7:4] configure channel 1 and bits [3:0] configure channel 0, each as {gate, source, m1, m0}. The two channels pick modes independently. A channel counts only while its run bit is 1 and either gate is 0 or its interrupt pin (after a two-flop synchroniser) is 1.
- R4: With source = 0 a channel counts the internal tick, one count per cycle that `tick` is high. With source = 1 it ignores the tick and counts once per rising edge of its count pin, taken after a two-flop synchroniser.
- R5: In mode 0 (m1:m0 = 00) only low-byte bits [4:0] count; bits [7:5] hold their value. A carry out of bit 4 advances the high byte. The wrap from count 0x1FFF sets the flag.
- R6: In mode 1 (01) {high, low} counts as 16 bits, and the wrap from 0xFFFF to 0x0000 sets the flag.
- R7: In mode 2 (10) only the low byte counts. On the count after 0xFF it loads the high byte's value and sets the flag; the high byte does not change.
- R8: In mode 3 (11) channel 0's low byte is an 8-bit counter under channel 0's run, gate and source and sets flag 0. Channel 0's high byte counts the internal tick under run bit 1 and sets flag 1 on its wrap from 0xFF. While channel 0 is in mode 3, channel 1 keeps counting but its wrap does not set flag 1. Channel 1 set to mode 3 holds its count.
- R9: A flag is set by its channel's overflow and cleared by `ack` for that channel. An overflow in the same cycle as the acknowledge leaves the flag set, and a control write overrides both. `ovf_pulse[i]` is high for exactly the one cycle after the edge at which flag i's overflow event occurs.
- R10: With its run bit at 0, a channel's count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Internal count tick, one-cycle pulses |
| cnt_pin | input | 2 | External count pins, bit i for channel i |
| irq_pin | input | 2 | External interrupt pins used for gating |
| ack | input | 2 | Interrupt acknowledge strobes, bit i clears flag i |
| mode_q | output | 8 | Mode register |
| ctrl_q | output | 4 | {flag1, run1, flag0, run0} |
| lo0 | output | 8 | Channel 0 low byte |
| hi0 | output | 8 | Channel 0 high byte |
| lo1 | output | 8 | Channel 1 low byte |
| hi1 | output | 8 | Channel 1 high byte |
| ovf_pulse | output | 2 | One-cycle overflow pulses |

## Verification
The bench targets the wrap points in every mode.

- **Mode 0.** A prescaler that used all eight low bits would never carry at 0x1F. It would also disturb low-byte bits [7:5].
- **Mode 2.** A reload that fetched the wrong byte, or that zeroed the low byte, gives the wrong value after 0xFF.
- **Split mode.** A design that left channel 1's wrap routed to flag 1 would raise that flag early. A design that never routed channel 0's high byte to flag 1 would never raise it.
- **Write against count.** A design that let the count win would show the written value plus one.
- **Acknowledge against overflow.** A design with clear-wins priority would lose an overflow that meets an acknowledge in the same cycle.
- **Gate and pin paths.** Gating off and pin counting are checked at the count bytes, and the tick must have no effect in pin mode.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int NCH    = 2;
  localparam int CFG_W  = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    MD_PRESCALE = 2'd0,
    MD_WIDE     = 2'd1,
    MD_RELOAD   = 2'd2,
    MD_SPLIT    = 2'd3
  } tc_mode_e;

  localparam logic [SEL_W-1:0] SEL_MODE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LO0  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HI0  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LO1  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_HI1  = 3'd5;
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int BW       = 8,
  parameter int PW       = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          lo_evt,
  input  logic          hi_evt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q,
  output logic          ovf_main,
  output logic          ovf_hi
);
  localparam logic [PW-1:0]   ONE_P = 1;
  localparam logic [BW-1:0]   ONE_B = 1;
  localparam logic [2*BW-1:0] ONE_W = 1;

  logic [BW-1:0] lo_n, hi_n;
  logic          busy;

  assign busy = wr_lo | wr_hi;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    case (mode)
      MD_PRESCALE: begin
        if (lo_evt && !busy) begin
          lo_n[PW-1:0] = lo_q[PW-1:0] + ONE_P;
          if (&lo_q[PW-1:0]) begin
            hi_n     = hi_q + ONE_B;
            ovf_main = &hi_q;
          end
        end
      end
      MD_WIDE: begin
        if (lo_evt && !busy) begin
          {hi_n, lo_n} = {hi_q, lo_q} + ONE_W;
          ovf_main     = &{hi_q, lo_q};
        end
      end
      MD_RELOAD: begin
        if (lo_evt && !busy) begin
          if (&lo_q) begin
            lo_n     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo_q + ONE_B;
          end
        end
      end
      default: begin
        if (SPLIT_OK) begin
          if (lo_evt && !wr_lo) begin
            lo_n     = lo_q + ONE_B;
            ovf_main = &lo_q;
          end
          if (hi_evt && !wr_hi) begin
            hi_n   = hi_q + ONE_B;
            ovf_hi = &hi_q;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wr_data : lo_n;
      hi_q <= wr_hi ? wr_data : hi_n;
    end
  end
endmodule

// File: rtl/tmrcnt_pair.sv
module tmrcnt_pair
  import tc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic             tick,
  input  logic [NCH-1:0]   cnt_pin,
  input  logic [NCH-1:0]   irq_pin,
  input  logic [NCH-1:0]   ack,
  output logic [BYTE_W-1:0] mode_q,
  output logic [3:0]       ctrl_q,
  output logic [BYTE_W-1:0] lo0,
  output logic [BYTE_W-1:0] hi0,
  output logic [BYTE_W-1:0] lo1,
  output logic [BYTE_W-1:0] hi1,
  output logic [NCH-1:0]   ovf_pulse
);
  logic [NCH-1:0] cnt_lvl, cnt_prev, cnt_rise, irq_lvl;
  logic [NCH-1:0] run_q, flag_q, flag_set;
  logic [NCH-1:0] lo_evt, hi_evt, ovf_main, ovf_hi;
  logic [NCH-1:0] wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo_arr [NCH];
  logic [BYTE_W-1:0] hi_arr [NCH];
  logic           split_on;

  tc_sync #(.W(NCH), .STAGES(2)) u_cnt_sync (
    .clk(clk), .rst(rst), .d(cnt_pin), .q(cnt_lvl));
  tc_sync #(.W(NCH), .STAGES(2)) u_irq_sync (
    .clk(clk), .rst(rst), .d(irq_pin), .q(irq_lvl));

  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= '0;
    else     cnt_prev <= cnt_lvl;
  end
  assign cnt_rise = cnt_lvl & ~cnt_prev;

  assign split_on = (mode_q[1:0] == MD_SPLIT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CFG_W-1:0] cfg;
    logic             src, en;
    assign cfg       = mode_q[CFG_W*i +: CFG_W];
    assign src       = cfg[2] ? cnt_rise[i] : tick;
    assign en        = run_q[i] & (~cfg[3] | irq_lvl[i]);
    assign lo_evt[i] = src & en;
    assign wr_lo[i]  = wr_en && (wr_sel == SEL_LO0 + SEL_W'(2*i));
    assign wr_hi[i]  = wr_en && (wr_sel == SEL_HI0 + SEL_W'(2*i));
    if (i == 0) begin : g_hi_split
      assign hi_evt[i] = run_q[1] & tick;
    end else begin : g_hi_none
      assign hi_evt[i] = 1'b0;
    end

    tc_channel #(.BW(BYTE_W), .PW(PRE_W), .SPLIT_OK(i == 0)) u_ch (
      .clk(clk), .rst(rst), .mode(cfg[1:0]),
      .lo_evt(lo_evt[i]), .hi_evt(hi_evt[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wr_data(wr_data),
      .lo_q(lo_arr[i]), .hi_q(hi_arr[i]),
      .ovf_main(ovf_main[i]), .ovf_hi(ovf_hi[i]));
  end

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split_on ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      run_q     <= '0;
      flag_q    <= '0;
      ovf_pulse <= '0;
    end else begin
      ovf_pulse <= flag_set;
      if (wr_en && wr_sel == SEL_MODE) mode_q <= wr_data;
      if (wr_en && wr_sel == SEL_CTRL) begin
        flag_q <= {wr_data[7], wr_data[5]};
        run_q  <= {wr_data[6], wr_data[4]};
      end else begin
        flag_q <= flag_set | (flag_q & ~ack);
      end
    end
  end

  assign ctrl_q = {flag_q[1], run_q[1], flag_q[0], run_q[0]};
  assign lo0 = lo_arr[0];
  assign hi0 = hi_arr[0];
  assign lo1 = lo_arr[1];
  assign hi1 = hi_arr[1];
endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import tc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [NCH-1:0]   ack,
  input logic [BYTE_W-1:0] mode_q,
  input logic [3:0]       ctrl_q,
  input logic [BYTE_W-1:0] lo0,
  input logic [BYTE_W-1:0] hi0,
  input logic [NCH-1:0]   ovf_pulse
);
  logic wr_ctrl, wr_lo0, wr_hi0;
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_lo0  = wr_en && (wr_sel == SEL_LO0);
  assign wr_hi0  = wr_en && (wr_sel == SEL_HI0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !wr_lo0 && !wr_hi0 && !wr_ctrl) |=> $stable(lo0));

  p_prescale_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1:0] == 2'd0 && !wr_lo0) |=> $stable(lo0[7:5]));

  p_reload_keeps_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1:0] == 2'd2 && !wr_hi0) |=> $stable(hi0));

  p_split_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse[1] && $past(mode_q[1:0]) == 2'd3) |-> (hi0 == 8'h00));

  p_flag_on_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse[0] && !$past(wr_ctrl)) |-> ctrl_q[1]);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && !wr_ctrl) |=> (!ctrl_q[1] || ovf_pulse[0]));
endmodule

bind tmrcnt_pair tc_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .ack(ack),
  .mode_q(mode_q), .ctrl_q(ctrl_q), .lo0(lo0), .hi0(hi0),
  .ovf_pulse(ovf_pulse));

// File: tb/tmrcnt_pair_tb.sv
`timescale 1ns/1ps
module tmrcnt_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = '0;
  logic [1:0] irq_pin = '0;
  logic [1:0] ack = '0;
  logic [7:0] mode_q, lo0, hi0, lo1, hi1;
  logic [3:0] ctrl_q;
  logic [1:0] ovf_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmrcnt_pair dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .cnt_pin(cnt_pin), .irq_pin(irq_pin), .ack(ack),
    .mode_q(mode_q), .ctrl_q(ctrl_q), .lo0(lo0), .hi0(hi0),
    .lo1(lo1), .hi1(hi1), .ovf_pulse(ovf_pulse));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // one count step of channel 0 low path per the mode rules: {ovf, hi, lo}
  function automatic logic [16:0] step(input logic [1:0] md,
                                       input logic [7:0] lo, input logic [7:0] hi);
    logic [16:0] r;
    r = {1'b0, hi, lo};
    case (md)
      2'd0: begin
        r[4:0] = lo[4:0] + 5'd1;
        if (lo[4:0] == 5'h1F) begin
          r[15:8] = hi + 8'd1;
          r[16]   = (hi == 8'hFF);
        end
      end
      2'd1: begin
        r[15:0] = {hi, lo} + 16'd1;
        r[16]   = ({hi, lo} == 16'hFFFF);
      end
      2'd2: begin
        if (lo == 8'hFF) begin r[7:0] = hi; r[16] = 1'b1; end
        else r[7:0] = lo + 8'd1;
      end
      default: begin
        r[7:0] = lo + 8'd1;
        r[16]  = (lo == 8'hFF);
      end
    endcase
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 mode", mode_q, 0);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 counts", {lo0, hi0, lo1, hi1}, 0);
    chk("R1 pulse", ovf_pulse, 0);

    // R6 16-bit wrap
    wr(3'd0, 8'h01); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ticks(3);
    chk("R6 wrap count", {hi0, lo0}, 16'h0000);
    chk("R6 flag set", ctrl_q, 4'b0011);
    chk("R9 pulse", ovf_pulse, 2'b01);
    idle(1);
    chk("R9 pulse one cycle", ovf_pulse, 2'b00);
    ack = 2'b01; idle(1); ack = 2'b00;
    chk("R9 ack clears", ctrl_q, 4'b0001);

    // R5 13-bit prescale, upper low bits held
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ticks(2);
    chk("R5 low byte", lo0, 8'hE0);
    chk("R5 high byte", hi0, 8'h00);
    chk("R5 flag", ctrl_q[1], 1);

    // R7 reload
    wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'hFE); wr(3'd3, 8'hF0); wr(3'd1, 8'h10);
    ticks(2);
    chk("R7 reloaded", lo0, 8'hF0);
    chk("R7 high kept", hi0, 8'hF0);
    chk("R7 flag", ctrl_q[1], 1);
    ticks(1);
    chk("R7 continues", lo0, 8'hF1);

    // R9 acknowledge and overflow in one cycle: flag stays set
    wr(3'd2, 8'hFF);
    ack = 2'b01; tick = 1'b1; idle(1); ack = 2'b00; tick = 1'b0;
    chk("R9 set wins over ack", ctrl_q[1], 1);
    chk("R9 collision count", lo0, 8'hF0);
    ack = 2'b01; idle(1); ack = 2'b00;
    chk("R9 later ack", ctrl_q[1], 0);

    // R10 run bit clear
    wr(3'd1, 8'h00);
    ticks(5);
    chk("R10 stopped", lo0, 8'hF0);

    // R3 gate
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    idle(3);
    ticks(4);
    chk("R3 gate low blocks", lo0, 8'h00);
    irq_pin = 2'b01; idle(3);
    ticks(4);
    chk("R3 gate high counts", lo0, 8'h04);
    irq_pin = 2'b00; idle(3);

    // R4 external pin source
    wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    ticks(6);
    chk("R4 tick ignored", lo0, 8'h00);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 2'b01; idle(2);
      cnt_pin = 2'b00; idle(2);
    end
    idle(4);
    chk("R4 pin edges", lo0, 8'h05);

    // R2 write beats count
    wr(3'd0, 8'h01);
    tick = 1'b1; wr(3'd2, 8'h40); tick = 1'b0;
    chk("R2 write wins", lo0, 8'h40);
    ticks(1);
    chk("R2 count after write", lo0, 8'h41);

    // R8 split mode
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd3, 8'hFE); wr(3'd2, 8'h10);
    wr(3'd1, 8'h50);
    ticks(1);
    chk("R8 ch1 wraps", {hi1, lo1}, 16'h0000);
    chk("R8 ch1 no flag", ctrl_q[3], 0);
    chk("R8 high half", hi0, 8'hFF);
    ticks(1);
    chk("R8 high wrap", hi0, 8'h00);
    chk("R8 flag1 from high", ctrl_q[3], 1);
    chk("R8 pulse1", ovf_pulse[1], 1);
    chk("R8 low half", lo0, 8'h12);

    // R8 channel 1 in mode 3 holds
    wr(3'd1, 8'h00); wr(3'd0, 8'h30); wr(3'd4, 8'h22); wr(3'd1, 8'h40);
    ticks(3);
    chk("R8 ch1 mode3 holds", lo1, 8'h22);

    // random runs against the step model (R5 R6 R7)
    wr(3'd1, 8'h00);
    for (int it = 0; it < 24; it++) begin
      logic [1:0] md;
      logic [7:0] elo, ehi;
      logic       eflag;
      logic [16:0] r;
      int n;
      md  = 2'($urandom_range(0, 2));
      elo = 8'($urandom);
      ehi = 8'($urandom);
      n   = $urandom_range(1, 40);
      if ((it % 4) == 0) begin elo = 8'hF8; ehi = 8'hFF; end
      eflag = 1'b0;
      wr(3'd0, {6'b0, md});
      wr(3'd2, elo); wr(3'd3, ehi);
      wr(3'd1, 8'h10);
      ticks(n);
      wr(3'd1, {2'b00, 1'b0, 1'b0, 4'h0} | ({8{1'b0}}));
      for (int k = 0; k < n; k++) begin
        r = step(md, elo, ehi);
        elo = r[7:0]; ehi = r[15:8]; eflag = eflag | r[16];
      end
      if (md == 2'd0) chk("R5 random", {hi0, lo0}, {ehi, elo});
      else if (md == 2'd1) chk("R6 random", {hi0, lo0}, {ehi, elo});
      else chk("R7 random", {hi0, lo0}, {ehi, elo});
    end

    // flag path on a random-style wrap in mode 1 (R6)
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ticks(1);
    chk("R6 no flag before wrap", ctrl_q[1], 0);
    ticks(1);
    chk("R6 flag at wrap", ctrl_q[1], 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule